// File: doc/BRIEF.md
# Agent Message Filter and Route Stamper

This block sits at a node between a processing agent and its cluster switch. Every message the switch broadcasts arrives on the inbound stream. The block compares the message's type field with a configured accepted type. This comparison is combinational. A message whose type does not match is consumed and discarded in the same cycle it is offered. A matching message is taken in and stamped. The node's own agent ID goes into the route slot that the message's visit count points at. The visit count then increases. The type field is replaced with a configured emission type. After a configured number of cycles, the stamped message is presented on the outbound stream.

A 48-bit message is laid out from MSB down as follows:
- a 4-bit tracking ID at bits 47:44;
- a 2-bit type at bits 43:42, with codes 01, 10 and 11, while 00 is never a valid type;
- a 2-bit visit count at bits 41:40;
- four 9-bit route slots, with slot 0 at bits 39:31, slot 1 at 30:22, slot 2 at 21:13 and slot 3 at 12:4;
- 4 reserved bits at 3:0.

Both streams use valid/ready:
- A transfer happens on a rising clock edge where valid and ready are both high.
- The block holds one message at a time. While that message waits for its delay or sits unaccepted on the output, inbound ready is low for matching messages. It stays high for messages that do not match, so they are still discarded.
- Once the outbound valid is raised, it stays high with the data unchanged until the consumer accepts the message.

Top module: `agent_msg_stamper`

## Requirements
- R1: A message whose type bits 43:42 equal `cfg_accept_kind` is accepted on the first edge where `in_valid` is high and the block holds no message. `in_ready` is high whenever no message is held.
- R2: A message whose type differs from `cfg_accept_kind`, including type 00, always sees `in_ready` high. It is discarded and produces no output.
- R3: In the stamped message, the route slot whose index equals the incoming visit count holds `cfg_agent_id`. The other slots keep their incoming values. Slot k occupies bits 39-9k down to 31-9k.
- R4: The outgoing visit count is the incoming count plus one. An incoming count of 3 stays at 3, and slot 3 is overwritten.
- R5: The outgoing type equals `cfg_emit_kind`, the tracking ID is unchanged, and the reserved bits 3:0 are zero.
- R6: `out_valid` rises exactly D rising edges after the accepting edge. D equals `cfg_delay`, except that a value of 0 acts as 1.
- R7: From the accepting edge until the output handshake completes, `in_ready` is low while a matching message is offered.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged. After the handshake edge, `out_valid` is low and the block accepts again.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: The agent ID, emission type and delay are sampled at the accepting edge. Changing them while a message is held does not affect that message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_agent_id | input | 9 | ID written into the route slot |
| cfg_accept_kind | input | 2 | Type code this node accepts |
| cfg_emit_kind | input | 2 | Type code placed on emitted messages |
| cfg_delay | input | 6 | Cycles from acceptance to emission (0 acts as 1) |
| in_valid | input | 1 | Inbound message valid |
| in_data | input | 48 | Inbound message |
| in_ready | output | 1 | Inbound ready |
| out_valid | output | 1 | Outbound message valid |
| out_data | output | 48 | Stamped outbound message |
| out_ready | input | 1 | Outbound ready |

## Verification
Random messages are drawn with random tracking IDs, types, visit counts and route contents, under random configuration, delays and output stalls. This separates the match from the discard path and tests each route-slot position, including saturation at count 3. Directed cases cover the following:
- type 00 and mismatched types, which must leave no trace on the output;
- a zero delay, which must act as one cycle;
- configuration changes during the hold, which must not alter the pending message;
- a matching message offered while one is held, which must be back-pressured.

// File: rtl/msg_stamp_pkg.sv
package msg_stamp_pkg;
  localparam int TRK_W   = 4;
  localparam int KIND_W  = 2;
  localparam int CNT_W   = 2;
  localparam int ID_W    = 9;
  localparam int SLOTS   = 4;
  localparam int RSV_W   = 4;
  localparam int DLY_W   = 6;
  localparam int ROUTE_W = ID_W * SLOTS;
  localparam int MSG_W   = TRK_W + KIND_W + CNT_W + ROUTE_W + RSV_W;

  typedef struct packed {
    logic [TRK_W-1:0]             trk;
    logic [KIND_W-1:0]            kind;
    logic [CNT_W-1:0]             visits;
    logic [0:SLOTS-1][ID_W-1:0]   route;
    logic [RSV_W-1:0]             rsvd;
  } msg_t;
endpackage

// File: rtl/msg_kind_match.sv
module msg_kind_match
  import msg_stamp_pkg::*;
(
  input  logic [KIND_W-1:0] msg_kind,
  input  logic [KIND_W-1:0] want_kind,
  output logic              hit
);
  // type 00 is never a valid code, so it never hits
  always_comb hit = (msg_kind == want_kind) && (msg_kind != '0);
endmodule

// File: rtl/msg_route_stamp.sv
module msg_route_stamp
  import msg_stamp_pkg::*;
(
  input  msg_t              msg_in,
  input  logic [ID_W-1:0]   agent_id,
  input  logic [KIND_W-1:0] emit_kind,
  output msg_t              msg_out
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [0:SLOTS-1][ID_W-1:0] new_route;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign new_route[s] = (msg_in.visits == CNT_W'(s)) ? agent_id : msg_in.route[s];
  end

  always_comb begin
    msg_out.trk    = msg_in.trk;
    msg_out.kind   = emit_kind;
    msg_out.visits = (msg_in.visits == CNT_MAX) ? CNT_MAX : msg_in.visits + 1'b1;
    msg_out.route  = new_route;
    msg_out.rsvd   = '0;
  end
endmodule

// File: rtl/msg_delay_hold.sv
module msg_delay_hold
  import msg_stamp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MSG_W-1:0] load_msg,
  input  logic [DLY_W-1:0] load_delay,
  output logic             busy,
  output logic             out_valid,
  output logic [MSG_W-1:0] out_data,
  input  logic             out_ready
);
  typedef enum logic [1:0] {H_IDLE, H_WAIT, H_SEND} hold_st_t;

  hold_st_t         st;
  logic [DLY_W-1:0] cnt;
  logic [MSG_W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= H_IDLE;
      cnt  <= '0;
      held <= '0;
    end else begin
      case (st)
        H_IDLE: if (load) begin
          held <= load_msg;
          cnt  <= (load_delay == '0) ? '0 : load_delay - 1'b1;
          st   <= H_WAIT;
        end
        H_WAIT: begin
          if (cnt == '0) st <= H_SEND;
          else           cnt <= cnt - 1'b1;
        end
        H_SEND: if (out_ready) st <= H_IDLE;
        default: st <= H_IDLE;
      endcase
    end
  end

  assign busy      = (st != H_IDLE);
  assign out_valid = (st == H_SEND);
  assign out_data  = held;

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R6
  min_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !out_valid);

  // R7
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid);
endmodule

// File: rtl/agent_msg_stamper.sv
module agent_msg_stamper
  import msg_stamp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  cfg_agent_id,
  input  logic [KIND_W-1:0] cfg_accept_kind,
  input  logic [KIND_W-1:0] cfg_emit_kind,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             in_valid,
  input  logic [MSG_W-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [MSG_W-1:0] out_data,
  input  logic             out_ready
);
  msg_t in_msg, stamped, out_msg;
  logic hit, busy, take;

  assign in_msg = msg_t'(in_data);

  msg_kind_match i_match (
    .msg_kind  (in_msg.kind),
    .want_kind (cfg_accept_kind),
    .hit       (hit)
  );

  msg_route_stamp i_stamp (
    .msg_in    (in_msg),
    .agent_id  (cfg_agent_id),
    .emit_kind (cfg_emit_kind),
    .msg_out   (stamped)
  );

  assign in_ready = !hit || !busy;
  assign take     = in_valid && hit && !busy;

  msg_delay_hold i_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (take),
    .load_msg   (stamped),
    .load_delay (cfg_delay),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready)
  );

  assign out_msg = msg_t'(out_data);

  // R2
  drop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_msg.kind != cfg_accept_kind) |-> in_ready);

  // R5
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_msg.rsvd == '0);

  // R4
  visits_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_msg.visits != '0);

  // R7
  hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && in_valid && hit |-> !in_ready);
endmodule

// File: tb/test_agent_msg_stamper.sv
module test_agent_msg_stamper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [8:0]  cfg_agent_id = '0;
  logic [1:0]  cfg_accept_kind = 2'b01;
  logic [1:0]  cfg_emit_kind = 2'b10;
  logic [5:0]  cfg_delay = 6'd2;
  logic        in_valid = 0;
  logic [47:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [47:0] out_data;
  logic        out_ready = 0;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  agent_msg_stamper i_agent_msg_stamper (
    .clk(clk), .rst_n(rst_n), .cfg_agent_id(cfg_agent_id),
    .cfg_accept_kind(cfg_accept_kind), .cfg_emit_kind(cfg_emit_kind),
    .cfg_delay(cfg_delay), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input logic [47:0] act, input logic [47:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [47:0] mk(logic [3:0] trk, logic [1:0] kind, logic [1:0] cnt,
                                      logic [8:0] s0, logic [8:0] s1, logic [8:0] s2, logic [8:0] s3);
    return {trk, kind, cnt, s0, s1, s2, s3, 4'b0000};
  endfunction

  // expected stamped message, from R3 R4 R5
  function automatic logic [47:0] expect_msg(logic [47:0] m, logic [8:0] id, logic [1:0] ek);
    logic [47:0] r;
    int c;
    r = m;
    c = int'(m[41:40]);
    r[39 - 9*c -: 9] = id;
    r[43:42] = ek;
    r[41:40] = (c == 3) ? 2'd3 : 2'(c + 1);
    r[3:0] = 4'b0000;
    return r;
  endfunction

  task automatic run_msg(input logic [47:0] m, input logic [8:0] id, input logic [1:0] ak,
                         input logic [1:0] ek, input logic [5:0] d, input int stall);
    bit match;
    int dexp, k;
    logic [47:0] exp;
    match = (m[43:42] == ak) && (m[43:42] != 2'b00);
    dexp  = (d == 0) ? 1 : int'(d);
    exp   = expect_msg(m, id, ek);
    @(negedge clk);
    cfg_agent_id = id; cfg_accept_kind = ak; cfg_emit_kind = ek; cfg_delay = d;
    in_valid = 1; in_data = m;
    #1;
    check(in_ready == 1, match ? "R1 ready when idle" : "R2 ready for mismatch",
          48'(in_ready), 48'd1);
    @(posedge clk); #1;
    in_valid = 0;
    if (!match) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        check(out_valid == 0, "R2 dropped message emitted", 48'(out_valid), 48'd0);
      end
      return;
    end
    @(negedge clk);
    k = 0;
    // R10: disturb configuration during the hold
    cfg_agent_id = ~id; cfg_emit_kind = ~ek; cfg_delay = d + 6'd5;
    in_valid = 1; in_data = m;
    #1;
    check(in_ready == 0, "R7 matching input not back-pressured", 48'(in_ready), 48'd0);
    in_valid = 0;
    while (!out_valid && k < 200) begin
      @(posedge clk); @(negedge clk); k++;
    end
    check(k == dexp, "R6 emission delay", 48'(k), 48'(dexp));
    check(out_data == exp, "R3/R4/R5/R10 stamped message", out_data, exp);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check(out_valid == 1 && out_data == exp, "R8 output held under stall", out_data, exp);
    end
    @(negedge clk);
    in_valid = 1; in_data = m; cfg_accept_kind = ak;
    #1;
    check(in_ready == 0, "R7 back-pressure while presenting", 48'(in_ready), 48'd0);
    in_valid = 0;
    out_ready = 1;
    @(posedge clk); #1;
    out_ready = 0;
    @(negedge clk);
    check(out_valid == 0 && in_ready == 1, "R8 release after handshake",
          {46'd0, out_valid, in_ready}, 48'd1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD*2 + 1);
    check(out_valid == 0, "R9 reset out_valid", 48'(out_valid), 48'd0);
    check(in_ready == 1, "R9 reset in_ready", 48'(in_ready), 48'd1);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0 && in_ready == 1, "R9 after reset release",
          {46'd0, out_valid, in_ready}, 48'd1);

    // directed corners
    run_msg(mk(4'hA, 2'b01, 2'd0, 9'h0, 9'h0, 9'h0, 9'h0), 9'h155, 2'b01, 2'b10, 6'd3, 2);  // R3 slot 0
    run_msg(mk(4'h3, 2'b11, 2'd2, 9'h11, 9'h22, 9'h0, 9'h0), 9'h0AB, 2'b11, 2'b01, 6'd0, 0); // R6 zero delay
    run_msg(mk(4'h7, 2'b10, 2'd3, 9'h1, 9'h2, 9'h3, 9'h4), 9'h1FF, 2'b10, 2'b11, 6'd1, 1);  // R4 saturate
    run_msg(mk(4'h5, 2'b00, 2'd1, 9'h9, 9'h0, 9'h0, 9'h0), 9'h010, 2'b01, 2'b10, 6'd2, 0);  // R2 type 00
    run_msg(mk(4'h6, 2'b10, 2'd1, 9'h9, 9'h0, 9'h0, 9'h0), 9'h010, 2'b01, 2'b10, 6'd2, 0);  // R2 mismatch
    run_msg(mk(4'hF, 2'b01, 2'd1, 9'h1AA, 9'h0, 9'h0, 9'h0), 9'h123, 2'b01, 2'b01, 6'd50, 3); // R1 long delay

    // constrained random
    for (int n = 0; n < 60; n++) begin
      logic [47:0] m;
      logic [1:0] ak, ek, kind;
      ak   = 2'($urandom_range(1, 3));
      ek   = 2'($urandom_range(1, 3));
      kind = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : ak;
      m = mk(4'($urandom), kind, 2'($urandom), 9'($urandom), 9'($urandom),
             9'($urandom), 9'($urandom));
      run_msg(m, 9'($urandom), ak, ek, 6'($urandom_range(0, 12)), int'($urandom_range(0, 3)));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule